// File: doc/BRIEF.md
# System-Management RAM Window Decoder

This block holds one programmable protected-memory window and classifies bus addresses against it. Software programs the window through a byte-wide configuration port with four registers. Two bytes give the base, at address bits 16 and 24. A size register gives a 4-bit count of 64 KB units. A control byte carries the enable. The window spans `base` up to, but not including, `base + size`. It is live only when the enable condition holds and the computed base is not zero.

Addresses to classify arrive on a valid/ready query stream. Each accepted query produces one registered result beat on a valid/ready result stream, carrying a hit flag. A query is accepted when `q_valid` and `q_ready` are both high at a rising edge. `q_ready` is high while the result slot is empty or is being drained in the same cycle (`!r_valid || r_ready`). While `r_valid` is high and `r_ready` is low, the result beat holds unchanged and no new query is taken. A parameter selects the enable polarity, so the same decoder can serve an agent that enables on a set bit and one that enables on a clear bit. A second parameter sets the reset value of the low base byte.

Top module: `smm_window_decoder`

## Requirements
- R1: The window base is the low base byte (select 0) placed at address bits 23:16, ORed with the high base byte (select 1) placed at bits 31:24. All lower bits are zero.
- R2: The window size is (bits 7:4 of the size register (select 2) + 1) × 64 KB. Bits 3:0 written to the size register are discarded and have no effect on decoding.
- R3: When the computed base is zero, no address hits, whatever the enable and size.
- R4: Only bit 3 of the control byte (select 3) is kept. With `EN_ACTIVE_LOW`=0 the window is enabled when that bit is 1. With `EN_ACTIVE_LOW`=1 it is enabled when that bit is 0. Every other control bit has no effect.
- R5: After reset the low base byte equals `BASE_LO_RST` (0x05 by default). The high base byte, the size field and the control bit are all 0.
- R6: A query hits exactly when the window is live and base ≤ address < base + size. The comparison is unsigned and carries one extra bit, so a window reaching past the top of the address space does not wrap.
- R7: A register write applies to queries accepted from the next rising edge on. A query accepted at the same edge as the write is decoded with the old window.
- R8: A query is accepted only when `q_ready` is high, and `q_ready` equals `!r_valid || r_ready`. While `r_valid` is high and `r_ready` is low, `r_valid` and `r_hit` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 2 | Register select: 0 base low, 1 base high, 2 size, 3 control |
| cfg_wdata | input | 8 | Configuration write byte |
| q_valid | input | 1 | Query address valid |
| q_ready | output | 1 | Query accepted when high together with q_valid |
| q_addr | input | 32 | Address to classify |
| r_valid | output | 1 | Result beat valid |
| r_ready | input | 1 | Result consumer ready |
| r_hit | output | 1 | Address lies inside the live window |

## Verification
The bench sweeps several high and low base bytes, all sixteen size codes and both enable settings. Two instances of opposite polarity share one configuration bus. Each window is probed just below its base, at its base, at its last byte, one past its end and at address zero, so off-by-one errors in either bound are caught. Junk bits in the size low nibble and in the unused control bits show whether those bits are masked. Zero-base windows separate the "base non-zero" rule from the enable rule. A full-top window separates a wrapping limit from an overflow-safe one. Dedicated cases check the reset decode, the old-versus-new window order for a write that lands with a query, and a stalled result beat.

// File: rtl/smw_pkg.sv
package smw_pkg;
  typedef enum logic [1:0] {
    SEL_BASE_LO = 2'd0,
    SEL_BASE_HI = 2'd1,
    SEL_SIZE    = 2'd2,
    SEL_CTRL    = 2'd3
  } cfg_sel_e;

  localparam int CTRL_EN_BIT = 3;
  localparam int NIB_W       = 4;
  localparam int BYTE_W      = 8;
endpackage

// File: rtl/smw_regs.sv
module smw_regs
  import smw_pkg::*;
#(
  parameter logic [7:0] BASE_LO_RST = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] base_lo,
  output logic [BYTE_W-1:0] base_hi,
  output logic [NIB_W-1:0]  size_nib,
  output logic              en_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo  <= BASE_LO_RST;
      base_hi  <= '0;
      size_nib <= '0;
      en_bit   <= 1'b0;
    end else if (cfg_we) begin
      unique case (cfg_sel_e'(cfg_sel))
        SEL_BASE_LO: base_lo  <= cfg_wdata;
        SEL_BASE_HI: base_hi  <= cfg_wdata;
        SEL_SIZE:    size_nib <= cfg_wdata[BYTE_W-1:BYTE_W-NIB_W];
        SEL_CTRL:    en_bit   <= cfg_wdata[CTRL_EN_BIT];
        default:     ;
      endcase
    end
  end

  // R2
  size_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_SIZE) |=> (size_nib == $past(cfg_wdata[7:4])));

  // R7
  ctrl_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_CTRL) |=> (en_bit == $past(cfg_wdata[CTRL_EN_BIT])));
endmodule

// File: rtl/smw_window.sv
module smw_window
  import smw_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BASE_LSB      = 16,
  parameter bit EN_ACTIVE_LOW = 1'b0
) (
  input  logic [BYTE_W-1:0] base_lo,
  input  logic [BYTE_W-1:0] base_hi,
  input  logic [NIB_W-1:0]  size_nib,
  input  logic              en_bit,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W:0]   win_limit,
  output logic              win_live
);
  localparam int BASE_W = 2 * BYTE_W;

  logic enabled;
  logic [ADDR_W:0] win_size;

  generate
    if (EN_ACTIVE_LOW) begin : g_pol_low
      assign enabled = ~en_bit;
    end else begin : g_pol_high
      assign enabled = en_bit;
    end
  endgenerate

  always_comb begin
    win_base  = ADDR_W'({base_hi, base_lo}) << BASE_LSB;
    win_size  = (ADDR_W+1)'({1'b0, size_nib} + 5'd1) << BASE_LSB;
    win_limit = {1'b0, win_base} + win_size;
    win_live  = enabled && (win_base != '0);
  end

  initial begin
    // R1
    base_fit_chk: assert (ADDR_W >= BASE_LSB + BASE_W);
  end
endmodule

// File: rtl/smw_lookup.sv
module smw_lookup #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              r_valid,
  input  logic              r_ready,
  output logic              r_hit,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W:0]   win_limit,
  input  logic              win_live
);
  logic take;
  logic in_range;

  assign q_ready  = !r_valid || r_ready;
  assign take     = q_valid && q_ready;
  assign in_range = (q_addr >= win_base) && ({1'b0, q_addr} < win_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_hit   <= 1'b0;
    end else begin
      if (take) begin
        r_valid <= 1'b1;
        r_hit   <= win_live && in_range;
      end else if (r_ready) begin
        r_valid <= 1'b0;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_hit)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |-> !q_ready);

  // R3
  zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && win_base == '0) |=> !r_hit);

  // R6
  below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && q_addr < win_base) |=> !r_hit);

  // R6
  past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && {1'b0, q_addr} >= win_limit) |=> !r_hit);
endmodule

// File: rtl/smm_window_decoder.sv
module smm_window_decoder
  import smw_pkg::*;
#(
  parameter int         ADDR_W        = 32,
  parameter int         BASE_LSB      = 16,
  parameter bit         EN_ACTIVE_LOW = 1'b0,
  parameter logic [7:0] BASE_LO_RST   = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              r_valid,
  input  logic              r_ready,
  output logic              r_hit
);
  logic [BYTE_W-1:0] base_lo, base_hi;
  logic [NIB_W-1:0]  size_nib;
  logic              en_bit;
  logic [ADDR_W-1:0] win_base;
  logic [ADDR_W:0]   win_limit;
  logic              win_live;

  smw_regs #(.BASE_LO_RST(BASE_LO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_lo(base_lo), .base_hi(base_hi),
    .size_nib(size_nib), .en_bit(en_bit)
  );

  smw_window #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB),
               .EN_ACTIVE_LOW(EN_ACTIVE_LOW)) u_window (
    .base_lo(base_lo), .base_hi(base_hi), .size_nib(size_nib),
    .en_bit(en_bit), .win_base(win_base), .win_limit(win_limit),
    .win_live(win_live)
  );

  smw_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
    .q_addr(q_addr), .r_valid(r_valid), .r_ready(r_ready), .r_hit(r_hit),
    .win_base(win_base), .win_limit(win_limit), .win_live(win_live)
  );
endmodule

// File: tb/test_smm_window_decoder.sv
module test_smm_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        q_valid = 1'b0;
  logic [31:0] q_addr = '0;
  logic        r_ready = 1'b1;
  logic        q_ready_h, q_ready_l, r_valid_h, r_valid_l, r_hit_h, r_hit_l;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  smm_window_decoder #(.EN_ACTIVE_LOW(1'b0), .BASE_LO_RST(8'h05)) i_smm_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .q_valid(q_valid), .q_ready(q_ready_h), .q_addr(q_addr),
    .r_valid(r_valid_h), .r_ready(r_ready), .r_hit(r_hit_h));

  smm_window_decoder #(.EN_ACTIVE_LOW(1'b1), .BASE_LO_RST(8'h0A)) i_smm_window_decoder_n (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .q_valid(q_valid), .q_ready(q_ready_l), .q_addr(q_addr),
    .r_valid(r_valid_l), .r_ready(r_ready), .r_hit(r_hit_l));

  function automatic logic model(input logic [7:0] lo, input logic [7:0] hi,
                                 input logic [3:0] nib, input logic en, input logic pol,
                                 input logic [31:0] a);
    logic [32:0] base, lim;
    base = {1'b0, hi, lo, 16'h0};
    lim  = base + ({29'd0, nib} + 33'd1) * 33'h10000;
    return ((pol ? !en : en) && base != 0 && {1'b0, a} >= base && {1'b0, a} < lim);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b addr=%h", req, act, exp, q_addr);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic query(input logic [31:0] a);
    @(negedge clk); q_valid = 1'b1; q_addr = a;
    @(negedge clk); q_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset decode
    query(32'h0005_0000); chk("R5 high-pol reset disabled", r_hit_h, 1'b0);
    chk("R5 low-pol reset enabled at 0xA0000", r_hit_l, 1'b0);
    query(32'h000A_0000); chk("R5 low-pol reset base 0x0A", r_hit_l, 1'b1);
    query(32'h000A_FFFF); chk("R5 low-pol reset last byte", r_hit_l, 1'b1);
    query(32'h000B_0000); chk("R5 low-pol reset 64KB size", r_hit_l, 1'b0);
    query(32'h0009_FFFF); chk("R5 low-pol below base", r_hit_l, 1'b0);
    chk("R8 result valid", r_valid_h, 1'b1);

    // R1 R2 R3 R4 R6 sweep
    for (int hi_i = 0; hi_i < 3; hi_i++) begin
      for (int lo_i = 0; lo_i < 4; lo_i++) begin
        for (int nb = 0; nb < 16; nb++) begin
          for (int en = 0; en < 2; en++) begin
            logic [7:0] hi, lo;
            logic [3:0] n4;
            logic [31:0] base, sz;
            hi = (hi_i == 0) ? 8'h00 : (hi_i == 1) ? 8'h12 : 8'hFF;
            lo = (lo_i == 0) ? 8'h00 : (lo_i == 1) ? 8'h01 : (lo_i == 2) ? 8'h80 : 8'hFF;
            n4 = 4'(nb);
            wr(2'd0, lo);
            wr(2'd1, hi);
            wr(2'd2, {n4, ~n4});
            wr(2'd3, en[0] ? 8'hFF : 8'hF7);
            base = {hi, lo, 16'h0};
            sz = ({28'd0, n4} + 32'd1) << 16;
            for (int p = 0; p < 5; p++) begin
              logic [31:0] a;
              case (p)
                0: a = base - 32'd1;
                1: a = base;
                2: a = base + sz - 32'd1;
                3: a = base + sz;
                default: a = 32'h0;
              endcase
              query(a);
              chk("R6/R1/R2/R3/R4 high-pol decode", r_hit_h, model(lo, hi, n4, en[0], 1'b0, a));
              chk("R6/R1/R2/R3/R4 low-pol decode", r_hit_l, model(lo, hi, n4, en[0], 1'b1, a));
            end
          end
        end
      end
    end

    // R7: write lands with query -> old window
    wr(2'd0, 8'h20); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h08);
    @(negedge clk); q_valid = 1'b1; q_addr = 32'h0020_1000;
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'h00;
    @(negedge clk); q_valid = 1'b0; cfg_we = 1'b0;
    chk("R7 same-edge query uses old window", r_hit_h, 1'b1);
    query(32'h0020_1000);
    chk("R7 next query uses new window", r_hit_h, 1'b0);

    // R8 back-pressure
    wr(2'd3, 8'h08);
    @(negedge clk); r_ready = 1'b0; q_valid = 1'b1; q_addr = 32'h0020_0000;
    @(negedge clk); q_addr = 32'h0040_0000;
    chk("R8 ready low while stalled", q_ready_h, 1'b0);
    @(negedge clk);
    chk("R8 stalled beat held valid", r_valid_h, 1'b1);
    chk("R8 stalled beat keeps first hit", r_hit_h, 1'b1);
    q_valid = 1'b0; r_ready = 1'b1;
    @(negedge clk);
    chk("R8 drained", r_valid_h, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule